// File: doc/BRIEF.md
# General-Purpose Event Status Router

This block holds a 32-bit bank of sticky event status flags and a matching bank of enable flags at the same bit positions. Hardware event sources set status flags; software clears them by writing a one to the flag's position through a small register port. A status flag that is set while its enable flag is also set is *pending*. Pending flags are routed to one of three level outputs, and the choice depends on the power state. While the system sleeps, they drive a wake request. In the working state, they raise a system control interrupt (SCI) or a system management interrupt (SMI), depending on two global control inputs.

Most sources are edge-type: a rising edge sets the flag once. Two sources are level-type, and their flag re-asserts for as long as the source stays active. The two power-management-event flags are masked from every output when the system sits in S5 that was reached through a power-button override. The routing outputs are registered.

Register map: `reg_sel_i` = 0 selects the status bank (read, write-one-to-clear). `reg_sel_i` = 1 selects the enable bank (read/write).

Top module: `gpe_status_router`

## Requirements
- R1: After reset, both banks read 0 and `wake_o`, `sci_o` and `smi_o` are 0.
- R2: For edge-type bits, a rising edge on `evt_i[n]` sets status bit n at the next clock edge. A source held high does not set the bit again after it has been cleared.
- R3: Writing the status bank (`reg_sel_i`=0) clears each bit where the write data is 1. Bits where the write data is 0 keep their value.
- R4: If a set request and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Bits 2 (software event) and 12 (management-engine request) are level-type. While their `evt_i` bit is 1, the status bit is set every cycle, so a clear does not hold. Once the source is 0, a clear holds.
- R6: Only bits 1–4, 6–15 and 17–19 are implemented, in both banks. Bit 10 is an implemented clearable bit. Bits 0, 5, 16 and 31:20 always read 0 and ignore writes and events.
- R7: `wake_o` is 1 when `slp_state_i` is 1 to 5 (S1–S5) and some status bit is set together with its enable bit. It is 0 in S0 (`slp_state_i`=0) and for codes 6 and 7.
- R8: In S0, when `sci_en_i`=1, `sci_o` is 1 whenever some status bit is set together with its enable bit.
- R9: In S0, when `sci_en_i`=0 and `smi_en_i`=1, `smi_o` is raised instead of `sci_o`. When both are 0, neither is raised. At most one of the three outputs is 1 at any time.
- R10: When `pbo_i`=1 and `slp_state_i`=5, bits 11 and 13 (power-management events) produce no output. Other bits still wake. With `pbo_i`=0, or in S1–S4, bits 11 and 13 wake normally.
- R11: A status bit whose enable bit is 0 produces no output. The outputs drop once every qualifying status bit is cleared.
- R12: The outputs are registered. A change in status, enable or control inputs shows on the outputs after one clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = status bank, 1 = enable bank |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected bank (combinational) |
| evt_i | input | 32 | Event source inputs, one per bit |
| slp_state_i | input | 3 | Power state: 0 = S0, 1..5 = S1..S5 |
| pbo_i | input | 1 | S5 was entered through power-button override |
| sci_en_i | input | 1 | Global SCI enable |
| smi_en_i | input | 1 | Global SMI enable |
| wake_o | output | 1 | Wake request |
| sci_o | output | 1 | System control interrupt |
| smi_o | output | 1 | System management interrupt |

## Verification
The hardest case to reach from the ports is a set request and a clear landing on the same bit in the same cycle. An edge-type bit only asks to be set on the single cycle its source rises. The bench first sets the bit and drops the source. It then drives the new rising edge and the write-one-to-clear strobe on the same falling clock edge, so that both are sampled by one rising edge. The override masking in S5 needs a second enabled bit that is not a power-management event, to show that only the two event bits are masked.

// File: rtl/gpe_pkg.sv
package gpe_pkg;

  localparam int GPE_W = 32;

  // bit positions the routing logic depends on
  localparam int BIT_SWGPE   = 2;
  localparam int BIT_PME     = 11;
  localparam int BIT_MESCI   = 12;
  localparam int BIT_PME_B0  = 13;

  localparam logic [GPE_W-1:0] GPE_IMPL_MASK  = 32'h000E_FFDE;
  localparam logic [GPE_W-1:0] GPE_LEVEL_MASK = (32'h1 << BIT_SWGPE) | (32'h1 << BIT_MESCI);
  localparam logic [GPE_W-1:0] GPE_PME_MASK   = (32'h1 << BIT_PME) | (32'h1 << BIT_PME_B0);

  typedef enum logic [2:0] {
    PS_S0 = 3'd0,
    PS_S1 = 3'd1,
    PS_S2 = 3'd2,
    PS_S3 = 3'd3,
    PS_S4 = 3'd4,
    PS_S5 = 3'd5
  } pwr_state_e;

  typedef enum logic {
    SEL_STS = 1'b0,
    SEL_EN  = 1'b1
  } bank_sel_e;

  typedef struct packed {
    logic wake;
    logic sci;
    logic smi;
  } route_t;

endpackage

// File: rtl/gpe_event_capture.sv
module gpe_event_capture
  import gpe_pkg::*;
#(
  parameter int              W          = GPE_W,
  parameter logic [W-1:0]    LEVEL_MASK = GPE_LEVEL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] set_o
);

  for (genvar i = 0; i < W; i++) begin : g_src
    if (LEVEL_MASK[i]) begin : g_level
      // level source: request a set every cycle it is active
      assign set_o[i] = evt_i[i];
    end else begin : g_edge
      logic prev_q;
      logic prev_d;

      always_comb prev_d = evt_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
      end

      assign set_o[i] = evt_i[i] & ~prev_q;
    end
  end

endmodule

// File: rtl/gpe_status_bank.sv
module gpe_status_bank
  import gpe_pkg::*;
#(
  parameter int           W         = GPE_W,
  parameter logic [W-1:0] IMPL_MASK = GPE_IMPL_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic         sel_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] sts_o,
  output logic [W-1:0] en_o
);

  logic [W-1:0] sts_q, sts_d;
  logic [W-1:0] en_q,  en_d;
  logic [W-1:0] clr_mask;
  logic         sts_ce, en_ce;
  logic         sts_wr, en_wr;

  always_comb begin
    sts_wr   = wr_i && (sel_i == SEL_STS);
    en_wr    = wr_i && (sel_i == SEL_EN);
    clr_mask = sts_wr ? wdata_i : '0;
    // set has priority over clear
    sts_d    = ((sts_q & ~clr_mask) | set_i) & IMPL_MASK;
    sts_ce   = sts_wr | (|(set_i & IMPL_MASK));
    en_d     = wdata_i & IMPL_MASK;
    en_ce    = en_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_comb begin
    rdata_o = (sel_i == SEL_EN) ? en_q : sts_q;
    sts_o   = sts_q;
    en_o    = en_q;
  end

endmodule

// File: rtl/gpe_route.sv
module gpe_route
  import gpe_pkg::*;
#(
  parameter int           W        = GPE_W,
  parameter logic [W-1:0] PME_MASK = GPE_PME_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sts_i,
  input  logic [W-1:0] en_i,
  input  logic [2:0]   slp_state_i,
  input  logic         pbo_i,
  input  logic         sci_en_i,
  input  logic         smi_en_i,
  output logic         wake_o,
  output logic         sci_o,
  output logic         smi_o
);

  route_t       rt_q, rt_d;
  logic [W-1:0] qual;
  logic         any_pend;
  logic         in_s0, asleep, pbo_s5;

  always_comb begin
    in_s0    = (slp_state_i == PS_S0);
    asleep   = (slp_state_i >= PS_S1) && (slp_state_i <= PS_S5);
    pbo_s5   = pbo_i && (slp_state_i == PS_S5);
    qual     = sts_i & en_i & (pbo_s5 ? ~PME_MASK : '1);
    any_pend = |qual;
    rt_d.wake = asleep && any_pend;
    rt_d.sci  = in_s0 && any_pend && sci_en_i;
    rt_d.smi  = in_s0 && any_pend && !sci_en_i && smi_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rt_q <= '0;
    else        rt_q <= rt_d;
  end

  assign wake_o = rt_q.wake;
  assign sci_o  = rt_q.sci;
  assign smi_o  = rt_q.smi;

endmodule

// File: rtl/gpe_status_router.sv
module gpe_status_router
  import gpe_pkg::*;
#(
  parameter int           W          = GPE_W,
  parameter logic [W-1:0] IMPL_MASK  = GPE_IMPL_MASK,
  parameter logic [W-1:0] LEVEL_MASK = GPE_LEVEL_MASK,
  parameter logic [W-1:0] PME_MASK   = GPE_PME_MASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr_i,
  input  logic         reg_sel_i,
  input  logic [W-1:0] reg_wdata_i,
  output logic [W-1:0] reg_rdata_o,
  input  logic [W-1:0] evt_i,
  input  logic [2:0]   slp_state_i,
  input  logic         pbo_i,
  input  logic         sci_en_i,
  input  logic         smi_en_i,
  output logic         wake_o,
  output logic         sci_o,
  output logic         smi_o
);

  logic [W-1:0] set_req;
  logic [W-1:0] sts_q;
  logic [W-1:0] en_q;

  gpe_event_capture #(.W(W), .LEVEL_MASK(LEVEL_MASK)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt_i),
    .set_o (set_req)
  );

  gpe_status_bank #(.W(W), .IMPL_MASK(IMPL_MASK)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_req),
    .wr_i    (reg_wr_i),
    .sel_i   (reg_sel_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .sts_o   (sts_q),
    .en_o    (en_q)
  );

  gpe_route #(.W(W), .PME_MASK(PME_MASK)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .sts_i       (sts_q),
    .en_i        (en_q),
    .slp_state_i (slp_state_i),
    .pbo_i       (pbo_i),
    .sci_en_i    (sci_en_i),
    .smi_en_i    (smi_en_i),
    .wake_o      (wake_o),
    .sci_o       (sci_o),
    .smi_o       (smi_o)
  );

endmodule

// File: rtl/gpe_status_router_chk.sv
module gpe_status_router_chk #(
  parameter int           W         = 32,
  parameter logic [W-1:0] IMPL_MASK = 32'h000E_FFDE,
  parameter logic [W-1:0] PME_MASK  = 32'h0000_2800
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr_i,
  input logic         reg_sel_i,
  input logic [W-1:0] reg_wdata_i,
  input logic [W-1:0] reg_rdata_o,
  input logic [W-1:0] sts_q,
  input logic [W-1:0] en_q,
  input logic [2:0]   slp_state_i,
  input logic         pbo_i,
  input logic         sci_en_i,
  input logic         smi_en_i,
  input logic         wake_o,
  input logic         sci_o,
  input logic         smi_o
);

  a_r6_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & ~IMPL_MASK) == '0);

  a_r3_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_q) & ~sts_q &
     ~($past(reg_wdata_i) & {W{$past(reg_wr_i) && !$past(reg_sel_i)}})) == '0);

  a_r7_wake_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> ($past(slp_state_i) != 3'd0 && $past(slp_state_i) <= 3'd5));

  a_r8_sci_needs_s0_en: assert property (@(posedge clk) disable iff (!rst_n)
    sci_o |-> ($past(slp_state_i) == 3'd0 && $past(sci_en_i)));

  a_r9_smi_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    smi_o |-> ($past(slp_state_i) == 3'd0 && !$past(sci_en_i) && $past(smi_en_i)));

  a_r9_one_output: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wake_o, sci_o, smi_o}));

  a_r11_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o || sci_o || smi_o) |-> ($past(sts_q & en_q) != '0));

  a_r10_pbo_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_o && $past(pbo_i) && $past(slp_state_i) == 3'd5)
      |-> ($past(sts_q & en_q & ~PME_MASK) != '0));

endmodule

bind gpe_status_router gpe_status_router_chk #(
  .W(W), .IMPL_MASK(IMPL_MASK), .PME_MASK(PME_MASK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .reg_sel_i   (reg_sel_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .sts_q       (sts_q),
  .en_q        (en_q),
  .slp_state_i (slp_state_i),
  .pbo_i       (pbo_i),
  .sci_en_i    (sci_en_i),
  .smi_en_i    (smi_en_i),
  .wake_o      (wake_o),
  .sci_o       (sci_o),
  .smi_o       (smi_o)
);

// File: tb/gpe_status_router_bench.sv
`timescale 1ns/1ps
module gpe_status_router_bench;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_i;
  logic        reg_sel_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic [31:0] evt_i;
  logic [2:0]  slp_state_i;
  logic        pbo_i;
  logic        sci_en_i;
  logic        smi_en_i;
  logic        wake_o;
  logic        sci_o;
  logic        smi_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  localparam logic [31:0] IMPL = 32'h000E_FFDE;

  gpe_status_router u_gpe_status_router (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .evt_i(evt_i),
    .slp_state_i(slp_state_i), .pbo_i(pbo_i), .sci_en_i(sci_en_i),
    .smi_en_i(smi_en_i), .wake_o(wake_o), .sci_o(sci_o), .smi_o(smi_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0; reg_wdata_i = '0;
  endtask

  task automatic bus_rd(input logic sel, output logic [31:0] d);
    reg_sel_i = sel;
    #0.5;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input int b);
    @(negedge clk); evt_i[b] = 1'b1;
    @(negedge clk); evt_i[b] = 1'b0;
  endtask

  task automatic ctl(input logic [2:0] st, input logic pbo, input logic sci, input logic smi);
    @(negedge clk);
    slp_state_i = st; pbo_i = pbo; sci_en_i = sci; smi_en_i = smi;
    @(negedge clk);
  endtask

  function automatic logic [31:0] outs();
    return {29'd0, wake_o, sci_o, smi_o};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(1'b0, d); chk("R1 status", d, 0);
    bus_rd(1'b1, d); chk("R1 enable", d, 0);
    chk("R1 outputs", outs(), 0);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(1);
    bus_rd(1'b0, d); chk("R2 edge set", d, 32'h2);
    bus_wr(1'b0, 32'h0);
    bus_rd(1'b0, d); chk("R3 write zero", d, 32'h2);
    bus_wr(1'b0, 32'h2);
    bus_rd(1'b0, d); chk("R3 write one", d, 32'h0);
  endtask

  task automatic t_edge_hold();
    logic [31:0] d;
    @(negedge clk); evt_i[7] = 1'b1;
    @(negedge clk);
    bus_wr(1'b0, 32'h80);
    repeat (2) @(negedge clk);
    bus_rd(1'b0, d); chk("R2 held source no reset", d, 32'h0);
    evt_i[7] = 1'b0;
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(9);
    @(negedge clk);
    evt_i[9] = 1'b1; reg_wr_i = 1'b1; reg_sel_i = 1'b0; reg_wdata_i = 32'h200;
    @(negedge clk);
    evt_i[9] = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    bus_rd(1'b0, d); chk("R4 set beats clear", d, 32'h200);
    bus_wr(1'b0, 32'h200);
    bus_rd(1'b0, d); chk("R4 later clear", d, 32'h0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    @(negedge clk); evt_i[2] = 1'b1; evt_i[12] = 1'b1;
    @(negedge clk);
    bus_wr(1'b0, 32'h1004);
    bus_rd(1'b0, d); chk("R5 level reasserts", d, 32'h1004);
    evt_i[2] = 1'b0; evt_i[12] = 1'b0;
    bus_wr(1'b0, 32'h1004);
    bus_rd(1'b0, d); chk("R5 clear after release", d, 32'h0);
  endtask

  task automatic t_rsvd();
    logic [31:0] d;
    bus_wr(1'b1, 32'hFFFF_FFFF);
    bus_rd(1'b1, d); chk("R6 enable mask", d, IMPL);
    bus_wr(1'b1, 32'h0);
    @(negedge clk); evt_i = 32'hFFFF_FFFF;
    @(negedge clk); evt_i = 32'h0;
    bus_rd(1'b0, d); chk("R6 status mask", d, IMPL);
    bus_wr(1'b0, 32'h0000_0400);
    bus_rd(1'b0, d); chk("R6 bit10 clearable", d, IMPL & ~32'h400);
    bus_wr(1'b0, 32'hFFFF_FFFF);
    bus_rd(1'b0, d); chk("R6 all cleared", d, 32'h0);
  endtask

  task automatic t_route();
    bus_wr(1'b1, 32'h2);
    ctl(3'd0, 1'b0, 1'b1, 1'b0);
    pulse(1);
    @(negedge clk);
    chk("R8 sci in S0", outs(), 32'h2);
    @(negedge clk); sci_en_i = 1'b0; smi_en_i = 1'b1;
    #0.5 chk("R12 no change before edge", outs(), 32'h2);
    @(negedge clk);
    chk("R9 smi when sci off", outs(), 32'h1);
    ctl(3'd0, 1'b0, 1'b0, 1'b0);
    chk("R9 neither gate", outs(), 32'h0);
    ctl(3'd3, 1'b0, 1'b1, 1'b1);
    chk("R7 wake in S3", outs(), 32'h4);
    ctl(3'd6, 1'b0, 1'b1, 1'b1);
    chk("R7 code 6 silent", outs(), 32'h0);
    ctl(3'd1, 1'b0, 1'b1, 1'b1);
    chk("R7 wake in S1", outs(), 32'h4);
    bus_wr(1'b0, 32'h2);
    @(negedge clk);
    chk("R11 drop on clear", outs(), 32'h0);
    pulse(6);
    @(negedge clk);
    chk("R11 disabled bit silent", outs(), 32'h0);
    bus_wr(1'b0, 32'h40);
  endtask

  task automatic t_pbo();
    bus_wr(1'b1, 32'h800);
    ctl(3'd5, 1'b1, 1'b0, 1'b0);
    pulse(11);
    @(negedge clk);
    chk("R10 pme masked pbo S5", outs(), 32'h0);
    ctl(3'd5, 1'b0, 1'b0, 1'b0);
    chk("R10 pme wakes normal S5", outs(), 32'h4);
    ctl(3'd4, 1'b1, 1'b0, 1'b0);
    chk("R10 pbo ignored in S4", outs(), 32'h4);
    ctl(3'd0, 1'b1, 1'b1, 1'b0);
    chk("R10 sci in S0", outs(), 32'h2);
    bus_wr(1'b1, 32'h0004_2000);
    pulse(13);
    ctl(3'd5, 1'b1, 1'b0, 1'b0);
    chk("R10 bus0 pme masked", outs(), 32'h0);
    pulse(18);
    @(negedge clk);
    chk("R10 other bit wakes", outs(), 32'h4);
    bus_wr(1'b0, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R11 all cleared", outs(), 32'h0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr_i = 1'b0; reg_sel_i = 1'b0; reg_wdata_i = '0;
    evt_i = '0; slp_state_i = 3'd0; pbo_i = 1'b0; sci_en_i = 1'b0; smi_en_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_w1c();
    t_edge_hold();
    t_set_wins();
    t_level();
    t_rsvd();
    t_route();
    t_pbo();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule